// File: doc/BRIEF.md
# Quad-Phase Multi-Sampling Time-to-Digital Converter Channel

This block timestamps transitions of one asynchronous hit signal with a resolution of a quarter of the reference clock period. The hit line is sampled four times per period: on the rising and falling edges of the reference clock and on the rising and falling edges of a second clock that lags it by 90 degrees. The four samples are moved into the reference clock domain together, as one 4-bit pattern per period. All later logic runs in that single domain.

A single qualification window scans the current pattern together with the last three samples of the period before. It accepts a transition only when the level before it and the level after it each last at least two samples. Each accepted edge is reported as a stamp. The upper bits of the stamp are a free-running period count. The two low bits give the phase index of the first sample taken at the new level. Leading edges always go out on their own lane. When the DUAL_EDGE parameter is set, trailing edges are qualified in the same way and reported on a second lane, so the lane that fires gives the edge type.

Top module: `qtdc_channel`

## Requirements
- R1: While rst_n is low, both valid outputs are low and all state is cleared. After reset is released, no valid pulse appears until a qualified edge is seen.
- R2: Sample phase index 0 is the rising edge of clk_ref, 1 is the rising edge of clk_q90, 2 is the falling edge of clk_ref and 3 is the falling edge of clk_q90. The fine field (stamp bits [1:0]) is the index of the first sample that sees the new level.
- R3: The coarse field (stamp bits [STAMP_W-1:2]) counts reference periods from 1 for the period that starts at the first rising clk_ref edge after reset release. It wraps modulo 2^COARSE_W, and it is the count of the period in which the edge was sampled.
- R4: A rising transition is reported on the lead lane when two low samples are followed by two high samples. The stamp is taken at the first high sample.
- R5: With DUAL_EDGE=1, a falling transition is reported on the trail lane when two high samples are followed by two low samples. The stamp is taken at the first low sample.
- R6: A level that holds for only one sample, whether a high spike or a low dropout, produces no report of either type.
- R7: For an edge whose first new-level sample falls in period k: if the fine value is 0, 1 or 2, the valid output is high for exactly one cycle following rising clk_ref edge k+3. If the fine value is 3, this happens following edge k+4.
- R8: With DUAL_EDGE=0, trail_valid never rises, and leading edges are reported exactly as in the dual-edge mode.
- R9: At most one edge of each type is reported per cycle. A leading and a trailing edge can be reported in the same cycle, and their stamps then differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; its edges give sample phases 0 and 2 |
| clk_q90 | input | 1 | Clock lagging clk_ref by 90 degrees; its edges give phases 1 and 3 |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 1 | Asynchronous hit signal to be timed |
| lead_valid | output | 1 | One-cycle strobe for a qualified rising edge |
| lead_stamp | output | COARSE_W+2 | Coarse period count and fine phase of the rising edge |
| trail_valid | output | 1 | One-cycle strobe for a qualified falling edge (dual-edge mode) |
| trail_stamp | output | COARSE_W+2 | Coarse period count and fine phase of the falling edge |

## Verification
A sample latched on the wrong phase, or a transfer layer that is one stage too short or too long, shows up at the ports as a stamp that is off by one fine step or by four. It also moves the valid strobe by one cycle, so the error is visible on the first edge reported after reset. A history register that loses the previous period's samples changes the stamps of edges near a period boundary, in particular phase-3 edges, on the first such edge. It can also let a one-sample spike or dropout through, which appears as an extra valid pulse within four cycles of the spike. A coarse count with the wrong offset shifts every stamp by a multiple of four. This is visible from the first report, and the counter's wrap is checked again after an idle gap longer than one full coarse cycle.

// File: rtl/qtdc_pkg.sv
package qtdc_pkg;

    // Number of sample phases per reference period (fixed quad scheme)
    localparam int unsigned PHASES   = 4;
    localparam int unsigned FINE_W   = $clog2(PHASES);
    // Samples of the previous period kept for the qualification window
    localparam int unsigned HIST_W   = PHASES - 1;
    localparam int unsigned WIN_W    = PHASES + HIST_W;
    // Reference cycles between a period's samples and its pattern in the
    // third register layer
    localparam int unsigned XFER_LAT = 2;

    typedef struct packed {
        logic              hit;
        logic              prev;   // edge sampled in the previous period
        logic [FINE_W-1:0] fine;
    } edge_t;

endpackage

// File: rtl/qtdc_sampler.sv
module qtdc_sampler
    import qtdc_pkg::*;
(
    input  logic              clk_ref,
    input  logic              clk_q90,
    input  logic              rst_n,
    input  logic              hit_in,
    output logic [PHASES-1:0] pat
);

    // Tap clocks in time order: 0, 90, 180, 270 degrees
    logic [PHASES-1:0] tap_clk;
    logic [PHASES-1:0] raw_w;

    assign tap_clk = {~clk_q90, ~clk_ref, clk_q90, clk_ref};

    // First layer: one flop per phase; the only metastable stage
    for (genvar p = 0; p < PHASES; p++) begin : g_tap
        logic tap_q;
        always_ff @(posedge tap_clk[p] or negedge rst_n) begin
            if (!rst_n) tap_q <= 1'b0;
            else        tap_q <= hit_in;
        end
        assign raw_w[p] = tap_q;
    end

    // Second and third layers in the reference domain
    typedef struct packed {
        logic [PHASES-1:0] mid;
        logic [PHASES-1:0] pat;
    } xfer_t;

    xfer_t xfer_d, xfer_q;

    always_comb begin
        xfer_d     = xfer_q;
        xfer_d.mid = raw_w;
        xfer_d.pat = xfer_q.mid;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) xfer_q <= '0;
        else        xfer_q <= xfer_d;
    end

    assign pat = xfer_q.pat;

endmodule

// File: rtl/qtdc_edge_qual.sv
module qtdc_edge_qual
    import qtdc_pkg::*;
(
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic [PHASES-1:0] pat,
    output edge_t             rise_o,
    output edge_t             fall_o
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;   // previous period, phases 1..3
    } qual_st_t;

    qual_st_t st_d, st_q;

    logic [WIN_W-1:0]  win;
    logic [PHASES-1:0] rise_c;
    logic [PHASES-1:0] fall_c;

    // Window bit 0 is the oldest sample; bits 3..6 are the current period
    assign win = {pat, st_q.hist};

    // Candidate c tests an edge at window bit c+2, using two bits each side
    for (genvar c = 0; c < PHASES; c++) begin : g_cand
        assign rise_c[c] = ~win[c] & ~win[c+1] &  win[c+2] &  win[c+3];
        assign fall_c[c] =  win[c] &  win[c+1] & ~win[c+2] & ~win[c+3];
    end

    function automatic edge_t pick_first(input logic [PHASES-1:0] cand);
        edge_t e;
        e = '0;
        for (int c = PHASES - 1; c >= 0; c--) begin
            if (cand[c]) begin
                e.hit  = 1'b1;
                e.prev = (c == 0);
                e.fine = FINE_W'(c + PHASES - 1);
            end
        end
        return e;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.hist = pat[PHASES-1:1];
        rise_o    = pick_first(rise_c);
        fall_o    = pick_first(fall_c);
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Window position of each reported edge, for the spacing check
    logic [FINE_W-1:0] rise_pos, fall_pos, pos_gap;
    assign rise_pos = rise_o.fine + FINE_W'(1);
    assign fall_pos = fall_o.fine + FINE_W'(1);
    assign pos_gap  = (rise_pos > fall_pos) ? (rise_pos - fall_pos) : (fall_pos - rise_pos);

    AST_ONE_RISE_PER_CYCLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $countones(rise_c) <= 1); // R9
    AST_ONE_FALL_PER_CYCLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $countones(fall_c) <= 1); // R9
    AST_EDGE_GAP: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (rise_o.hit && fall_o.hit) |-> (pos_gap >= 2)); // R6

endmodule

// File: rtl/qtdc_coarse.sv
module qtdc_coarse #(
    parameter int unsigned COUNT_W = 6
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    output logic [COUNT_W-1:0] count
);

    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
    } coarse_st_t;

    coarse_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + COUNT_W'(1);
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/qtdc_channel.sv
module qtdc_channel
    import qtdc_pkg::*;
#(
    parameter int unsigned COARSE_W  = 6,
    parameter bit          DUAL_EDGE = 1'b1
) (
    input  logic                       clk_ref,
    input  logic                       clk_q90,
    input  logic                       rst_n,
    input  logic                       hit_in,
    output logic                       lead_valid,
    output logic [COARSE_W+FINE_W-1:0] lead_stamp,
    output logic                       trail_valid,
    output logic [COARSE_W+FINE_W-1:0] trail_stamp
);

    localparam int unsigned           STAMP_W = COARSE_W + FINE_W;
    localparam logic [COARSE_W-1:0]   LAG_CUR = COARSE_W'(XFER_LAT);

    logic [PHASES-1:0]   pat_w;
    logic [COARSE_W-1:0] count_w;
    edge_t               rise_w, fall_w, fall_use;

    qtdc_sampler u_sampler (
        .clk_ref (clk_ref),
        .clk_q90 (clk_q90),
        .rst_n   (rst_n),
        .hit_in  (hit_in),
        .pat     (pat_w)
    );

    qtdc_edge_qual u_qual (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .pat     (pat_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    qtdc_coarse #(.COUNT_W(COARSE_W)) u_coarse (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .count   (count_w)
    );

    // Edge-type variant: the trailing lane exists only in dual-edge mode
    if (DUAL_EDGE) begin : g_dual
        assign fall_use = fall_w;
    end else begin : g_lead_only
        assign fall_use = '0;
    end

    // Coarse value of the period the edge was sampled in
    function automatic logic [STAMP_W-1:0] make_stamp(input edge_t e,
                                                      input logic [COARSE_W-1:0] cnt);
        logic [COARSE_W-1:0] back;
        back = LAG_CUR + COARSE_W'(e.prev);
        return {cnt - back, e.fine};
    endfunction

    typedef struct packed {
        logic               lv;
        logic [STAMP_W-1:0] ls;
        logic               tv;
        logic [STAMP_W-1:0] ts;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d    = out_q;
        out_d.lv = rise_w.hit;
        out_d.tv = fall_use.hit;
        if (rise_w.hit)   out_d.ls = make_stamp(rise_w, count_w);
        if (fall_use.hit) out_d.ts = make_stamp(fall_use, count_w);
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign lead_valid  = out_q.lv;
    assign lead_stamp  = out_q.ls;
    assign trail_valid = out_q.tv;
    assign trail_stamp = out_q.ts;

    AST_STAMP_DISTINCT: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (lead_valid && trail_valid) |-> (lead_stamp != trail_stamp)); // R9

endmodule

// File: tb/qtdc_channel_tb_top.sv
`timescale 1ns/1ps
module qtdc_channel_tb_top;

    localparam int unsigned CW      = 6;
    localparam int unsigned SW      = CW + 2;
    localparam longint      SMOD    = 64'd1 << SW;
    localparam int          PERIOD  = 8;

    logic clk_ref = 1'b0;
    logic clk_q90 = 1'b0;
    logic rst_n   = 1'b0;
    logic hit     = 1'b0;

    logic          d_lv, d_tv, s_lv, s_tv;
    logic [SW-1:0] d_ls, d_ts, s_ls, s_ts;

    int     n_tests = 0;
    int     n_fail  = 0;
    bit     done    = 1'b0;
    longint t1      = 0;

    int     ev_cnt   [4];
    longint ev_stamp [4];
    longint ev_time  [4];

    initial forever #(PERIOD/2) clk_ref = ~clk_ref;
    initial begin
        #(PERIOD/4);
        forever #(PERIOD/2) clk_q90 = ~clk_q90;
    end

    qtdc_channel #(.COARSE_W(CW), .DUAL_EDGE(1'b1)) dut_i (
        .clk_ref (clk_ref), .clk_q90 (clk_q90), .rst_n (rst_n), .hit_in (hit),
        .lead_valid (d_lv), .lead_stamp (d_ls),
        .trail_valid (d_tv), .trail_stamp (d_ts)
    );

    qtdc_channel #(.COARSE_W(CW), .DUAL_EDGE(1'b0)) dut_lead_i (
        .clk_ref (clk_ref), .clk_q90 (clk_q90), .rst_n (rst_n), .hit_in (hit),
        .lead_valid (s_lv), .lead_stamp (s_ls),
        .trail_valid (s_tv), .trail_stamp (s_ts)
    );

    // Monitor away from the active edge; records the posedge of each report
    always @(negedge clk_ref) begin
        if (rst_n) begin
            if (d_lv) begin ev_cnt[0]++; ev_stamp[0] = d_ls; ev_time[0] = $time - PERIOD/2; end
            if (d_tv) begin ev_cnt[1]++; ev_stamp[1] = d_ts; ev_time[1] = $time - PERIOD/2; end
            if (s_lv) begin ev_cnt[2]++; ev_stamp[2] = s_ls; ev_time[2] = $time - PERIOD/2; end
            if (s_tv) begin ev_cnt[3]++; ev_stamp[3] = s_ts; ev_time[3] = $time - PERIOD/2; end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic clear_ev();
        for (int i = 0; i < 4; i++) begin
            ev_cnt[i] = 0; ev_stamp[i] = -1; ev_time[i] = -1;
        end
    endtask

    // Transition at odd time t is first seen by the sample at t+1
    function automatic longint exp_stamp(input longint t);
        return (((t + 1 - t1) / 2) + 4) % SMOD;
    endfunction

    function automatic longint exp_time(input longint t);
        longint idx, k, p;
        idx = (t + 1 - t1) / 2;
        k   = idx / 4 + 1;
        p   = idx % 4;
        return t1 + PERIOD * (k + 2) + ((p == 3) ? PERIOD : 0);
    endfunction

    task automatic t_reset();
        #(PERIOD * 3 + 1);
        chk("R1 lead_valid in reset", d_lv, 0);
        chk("R1 trail_valid in reset", d_tv, 0);
        rst_n = 1'b1;
        @(posedge clk_ref);
        t1 = $time;
        clear_ev();
        repeat (8) @(posedge clk_ref);
        #1;
        chk("R1 no lead report after reset", ev_cnt[0], 0);
        chk("R1 no trail report after reset", ev_cnt[1], 0);
    endtask

    task automatic t_pulse(input int off, input int width, input string tag);
        longint tr, tf;
        clear_ev();
        @(posedge clk_ref);
        #(off) hit = 1'b1;
        tr = $time;
        #(width) hit = 1'b0;
        tf = $time;
        repeat (8) @(posedge clk_ref);
        #1;
        chk({tag, " R4 lead count"}, ev_cnt[0], 1);
        chk({tag, " R2 R3 lead stamp"}, ev_stamp[0], exp_stamp(tr));
        chk({tag, " R7 lead time"}, ev_time[0], exp_time(tr));
        chk({tag, " R5 trail count"}, ev_cnt[1], 1);
        chk({tag, " R2 R3 trail stamp"}, ev_stamp[1], exp_stamp(tf));
        chk({tag, " R7 trail time"}, ev_time[1], exp_time(tf));
        chk({tag, " R8 lead-only lead stamp"}, ev_stamp[2], exp_stamp(tr));
        chk({tag, " R8 lead-only no trail"}, ev_cnt[3], 0);
    endtask

    task automatic t_same_cycle();
        t_pulse(7, 4, "same-cycle");
        chk("R9 both lanes in one cycle", ev_time[0], ev_time[1]);
    endtask

    task automatic t_spike();
        clear_ev();
        @(posedge clk_ref);
        #3 hit = 1'b1;
        #2 hit = 1'b0;
        repeat (8) @(posedge clk_ref);
        #1;
        chk("R6 spike lead count", ev_cnt[0], 0);
        chk("R6 spike trail count", ev_cnt[1], 0);
        chk("R6 spike lead-only count", ev_cnt[2], 0);
    endtask

    task automatic t_dropout();
        longint tr, tf;
        clear_ev();
        @(posedge clk_ref);
        #3 hit = 1'b1;
        tr = $time;
        #20 hit = 1'b0;
        #2  hit = 1'b1;
        #20 hit = 1'b0;
        tf = $time;
        repeat (8) @(posedge clk_ref);
        #1;
        chk("R6 dropout lead count", ev_cnt[0], 1);
        chk("R6 dropout lead stamp", ev_stamp[0], exp_stamp(tr));
        chk("R6 dropout trail count", ev_cnt[1], 1);
        chk("R6 dropout trail stamp", ev_stamp[1], exp_stamp(tf));
    endtask

    task automatic t_wrap();
        repeat (70) @(posedge clk_ref);
        t_pulse(5, 12, "R3 after coarse wrap");
    endtask

    initial begin
        clear_ev();
        t_reset();
        t_pulse(1, 20, "phase1");
        t_pulse(3, 20, "phase2");
        t_pulse(5, 20, "phase3");
        t_pulse(7, 20, "phase0");
        t_pulse(1, 4, "min-width");
        t_same_cycle();
        t_spike();
        t_dropout();
        t_wrap();
        summary();
    end

    initial begin
        #(PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule